// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two bidirectional data ports, A and B, through a set of independent lanes, each one byte wide by default, each with its own controls. Every lane holds two storage registers: one keeps a copy of port A data and the other a copy of port B data. A lane either isolates both ports or drives exactly one of them. The driven port carries either the live value from the opposite port or the stored copy taken from that opposite port, as chosen by a per-direction source select.

Bidirectional pins are split into an input vector, an output vector and a per-lane output enable for each port, so the block can be synthesized and the pad ring supplies the tristate buffers. Storage registers load on a per-register capture strobe sampled on the common clock. Loading depends only on the strobe, so a port can be sampled while isolated and the value replayed later while the live data moves on.

Top module: `xcvr_dual`

## Requirements
- R1: Lanes are independent. The controls, strobes and data of one lane never change the outputs or the stored values of another lane.
- R2: When `cap_a[l]` (or `cap_b[l]`) is high at a rising clock edge, lane l's A-copy (B-copy) register loads that lane's `a_in` (`b_in`) slice. This happens whatever the values of `oe_n`, `dir` and the selects, and the new value shows on the stored path from the next cycle.
- R3: With `oe_n[l]` = 1 the lane is isolated: `a_oe[l]` = 0 and `b_oe[l]` = 0.
- R4: With `oe_n[l]` = 0 and `dir[l]` = 0, port A is driven (`a_oe[l]` = 1, `b_oe[l]` = 0). `a_out` for the lane equals `b_in` in the same cycle when `sel_ba[l]` = 0, and the B-copy register when `sel_ba[l]` = 1.
- R5: With `oe_n[l]` = 0 and `dir[l]` = 1, port B is driven (`b_oe[l]` = 1, `a_oe[l]` = 0). `b_out` for the lane equals `a_in` in the same cycle when `sel_ab[l]` = 0, and the A-copy register when `sel_ab[l]` = 1.
- R6: `a_oe[l]` and `b_oe[l]` are never both 1.
- R7: A synchronous active-high `rst` clears all storage registers to zero.
- R8: A storage register keeps its value in every cycle in which its strobe is low.
- R9: An output slice whose enable is 0 reads all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| oe_n | input | LANES | Per-lane output enable, active low |
| dir | input | LANES | Per-lane direction: 0 drives A, 1 drives B |
| sel_ab | input | LANES | Source for port B: 0 live A, 1 stored A |
| sel_ba | input | LANES | Source for port A: 0 live B, 1 stored B |
| cap_a | input | LANES | Load strobe for the A-copy registers |
| cap_b | input | LANES | Load strobe for the B-copy registers |
| a_in | input | LANES*LANE_W | Port A input data |
| b_in | input | LANES*LANE_W | Port B input data |
| a_out | output | LANES*LANE_W | Port A output data |
| b_out | output | LANES*LANE_W | Port B output data |
| a_oe | output | LANES | Port A drive enable per lane |
| b_oe | output | LANES | Port B drive enable per lane |

## Verification
The hardest case to reach is a value captured while the lane is isolated, or while it drives the opposite port, and then replayed after the live input has moved on. The stimulus captures under `oe_n` = 1, changes the input and stops the strobe, then turns on the stored path and expects the old byte, not the current one. For lane independence, one lane is strobed while the other replays, so cross-talk appears as a wrong stored value. A walk over every enable, direction and select combination per lane is followed by a long random run compared each cycle against a behavioural model.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  typedef enum logic [1:0] {
    DRV_NONE = 2'd0,
    DRV_A    = 2'd1,
    DRV_B    = 2'd2
  } drive_e;

  function automatic drive_e decode_drive(input logic oe_n, input logic dir);
    if (oe_n)     return DRV_NONE;
    else if (dir) return DRV_B;
    else          return DRV_A;
  endfunction
endpackage

// File: rtl/xcvr_store_reg.sv
module xcvr_store_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cap,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)      q <= '0;
    else if (cap) q <= d;
  end
endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane
  import xcvr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         oe_n,
  input  logic         dir,
  input  logic         sel_ab,
  input  logic         sel_ba,
  input  logic         cap_a,
  input  logic         cap_b,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] a_out,
  output logic [W-1:0] b_out,
  output logic         a_oe,
  output logic         b_oe
);
  logic [W-1:0] copy_a, copy_b;
  logic [W-1:0] src_to_a, src_to_b;
  drive_e       drv;

  xcvr_store_reg #(.W(W)) u_copy_a (
    .clk(clk), .rst(rst), .cap(cap_a), .d(a_in), .q(copy_a)
  );
  xcvr_store_reg #(.W(W)) u_copy_b (
    .clk(clk), .rst(rst), .cap(cap_b), .d(b_in), .q(copy_b)
  );

  always_comb begin
    drv      = decode_drive(oe_n, dir);
    src_to_a = sel_ba ? copy_b : b_in;
    src_to_b = sel_ab ? copy_a : a_in;
    a_oe     = (drv == DRV_A);
    b_oe     = (drv == DRV_B);
    a_out    = a_oe ? src_to_a : '0;
    b_out    = b_oe ? src_to_b : '0;
  end

  // R6
  oe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(a_oe && b_oe));

  // R3
  isolate_chk: assert property (@(posedge clk) disable iff (rst)
    oe_n |-> (!a_oe && !b_oe && a_out == '0 && b_out == '0));

  // R2
  replay_a_chk: assert property (@(posedge clk) disable iff (rst)
    (b_oe && sel_ab && $past(cap_a) && !$past(rst)) |-> (b_out == $past(a_in)));

  // R2
  replay_b_chk: assert property (@(posedge clk) disable iff (rst)
    (a_oe && sel_ba && $past(cap_b) && !$past(rst)) |-> (a_out == $past(b_in)));

  // R8
  hold_a_chk: assert property (@(posedge clk) disable iff (rst)
    (b_oe && sel_ab && $past(b_oe) && $past(sel_ab) && !$past(cap_a) && !$past(rst))
      |-> $stable(b_out));

  // R5
  live_ab_chk: assert property (@(posedge clk) disable iff (rst)
    (!oe_n && dir && !sel_ab) |-> (b_out == a_in && !a_oe));

  // R4
  live_ba_chk: assert property (@(posedge clk) disable iff (rst)
    (!oe_n && !dir && !sel_ba) |-> (a_out == b_in && !b_oe));
endmodule

// File: rtl/xcvr_dual.sv
module xcvr_dual #(
  parameter int LANES  = 2,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [LANES-1:0]        oe_n,
  input  logic [LANES-1:0]        dir,
  input  logic [LANES-1:0]        sel_ab,
  input  logic [LANES-1:0]        sel_ba,
  input  logic [LANES-1:0]        cap_a,
  input  logic [LANES-1:0]        cap_b,
  input  logic [LANES*LANE_W-1:0] a_in,
  input  logic [LANES*LANE_W-1:0] b_in,
  output logic [LANES*LANE_W-1:0] a_out,
  output logic [LANES*LANE_W-1:0] b_out,
  output logic [LANES-1:0]        a_oe,
  output logic [LANES-1:0]        b_oe
);
  localparam int BUS_W = LANES * LANE_W;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    localparam int LO = l * LANE_W;
    xcvr_lane #(.W(LANE_W)) u_lane (
      .clk   (clk),
      .rst   (rst),
      .oe_n  (oe_n[l]),
      .dir   (dir[l]),
      .sel_ab(sel_ab[l]),
      .sel_ba(sel_ba[l]),
      .cap_a (cap_a[l]),
      .cap_b (cap_b[l]),
      .a_in  (a_in[LO +: LANE_W]),
      .b_in  (b_in[LO +: LANE_W]),
      .a_out (a_out[LO +: LANE_W]),
      .b_out (b_out[LO +: LANE_W]),
      .a_oe  (a_oe[l]),
      .b_oe  (b_oe[l])
    );
  end

  // R9
  quiet_bus_chk: assert property (@(posedge clk) disable iff (rst)
    ((a_oe == '0) |-> (a_out == {BUS_W{1'b0}})));
endmodule

// File: tb/test_xcvr_dual.sv
module test_xcvr_dual;
  localparam int NL = 2;
  localparam int W  = 8;

  logic clk = 1'b0;
  logic rst;
  logic [NL-1:0] oe_n, dir, sel_ab, sel_ba, cap_a, cap_b;
  logic [NL*W-1:0] a_in, b_in, a_out, b_out;
  logic [NL-1:0] a_oe, b_oe;

  int checks = 0;
  int errors = 0;
  string cur_req = "R7";
  bit done = 0;

  logic [W-1:0] m_a [NL];
  logic [W-1:0] m_b [NL];

  always #2 clk = ~clk;

  xcvr_dual #(.LANES(NL), .LANE_W(W)) i_xcvr_dual (
    .clk(clk), .rst(rst), .oe_n(oe_n), .dir(dir), .sel_ab(sel_ab),
    .sel_ba(sel_ba), .cap_a(cap_a), .cap_b(cap_b), .a_in(a_in), .b_in(b_in),
    .a_out(a_out), .b_out(b_out), .a_oe(a_oe), .b_oe(b_oe)
  );

  // behavioural model of the storage (R2, R7, R8)
  always @(posedge clk) begin
    for (int l = 0; l < NL; l++) begin
      if (rst) begin
        m_a[l] <= '0;
        m_b[l] <= '0;
      end else begin
        if (cap_a[l]) m_a[l] <= a_in[l*W +: W];
        if (cap_b[l]) m_b[l] <= b_in[l*W +: W];
      end
    end
  end

  task automatic compare();
    for (int l = 0; l < NL; l++) begin
      logic ea, eb;
      logic [W-1:0] xa, xb;
      ea = !oe_n[l] && !dir[l];
      eb = !oe_n[l] && dir[l];
      xa = ea ? (sel_ba[l] ? m_b[l] : b_in[l*W +: W]) : '0;
      xb = eb ? (sel_ab[l] ? m_a[l] : a_in[l*W +: W]) : '0;
      checks++;
      if ({a_oe[l], b_oe[l], a_out[l*W +: W], b_out[l*W +: W]} !== {ea, eb, xa, xb}) begin
        errors++;
        $display("FAIL %s lane %0d: got oe=%b%b a=%h b=%h, expected oe=%b%b a=%h b=%h",
                 cur_req, l, a_oe[l], b_oe[l], a_out[l*W +: W], b_out[l*W +: W],
                 ea, eb, xa, xb);
      end
      checks++;
      if (a_oe[l] && b_oe[l]) begin
        errors++;
        $display("FAIL R6 lane %0d: got both enables 11, expected at most one", l);
      end
    end
  endtask

  // drive at negedge, compare 1 ns later, model updates at posedge
  task automatic step(input logic [NL-1:0] on, input logic [NL-1:0] d,
                      input logic [NL-1:0] sab, input logic [NL-1:0] sba,
                      input logic [NL-1:0] ca, input logic [NL-1:0] cb,
                      input logic [NL*W-1:0] ai, input logic [NL*W-1:0] bi);
    @(negedge clk);
    oe_n = on; dir = d; sel_ab = sab; sel_ba = sba;
    cap_a = ca; cap_b = cb; a_in = ai; b_in = bi;
    #1 compare();
  endtask

  initial begin
    rst = 1'b1;
    oe_n = '1; dir = '0; sel_ab = '0; sel_ba = '0;
    cap_a = '0; cap_b = '0; a_in = '0; b_in = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R7: stored path reads zero right after reset, live inputs nonzero
    cur_req = "R7";
    step('0, 2'b01, '1, '1, '0, '0, 16'hA5A5, 16'h5A5A);
    step('0, 2'b10, '1, '1, '0, '0, 16'h1234, 16'h4321);

    // R2: capture while isolated, then replay after input moves on
    cur_req = "R2";
    step('1, '0, '0, '0, '1, '1, 16'hC3_3C, 16'h96_69);
    step('1, '0, '0, '0, '0, '0, 16'h00_FF, 16'hFF_00);
    step('0, 2'b11, '1, '1, '0, '0, 16'h11_22, 16'h33_44);
    step('0, 2'b00, '1, '1, '0, '0, 16'h55_66, 16'h77_88);

    // R8: hold stored value across many cycles of changing input
    cur_req = "R8";
    for (int i = 0; i < 8; i++)
      step('0, 2'b11, '1, '1, '0, '0, 16'($urandom), 16'($urandom));

    // R1: strobe lane 0 only while lane 1 replays
    cur_req = "R1";
    step('0, 2'b11, '1, '1, 2'b01, 2'b01, 16'hEE_0E, 16'hDD_0D);
    step('0, 2'b11, '1, '1, '0, '0, 16'h00_00, 16'h00_00);
    step('0, 2'b00, '1, '1, '0, '0, 16'hFF_FF, 16'hFF_FF);

    // R3 R4 R5 R9: every oe/dir/select combination per lane
    for (int c = 0; c < 16; c++) begin
      logic [3:0] k;
      k = 4'(c);
      cur_req = k[0] ? "R3" : (k[1] ? "R5" : "R4");
      step({k[0], ~k[0]}, {k[1], ~k[1]}, {k[2], k[3]}, {k[3], k[2]},
           2'($urandom), 2'($urandom), 16'($urandom), 16'($urandom));
    end

    // random soak against the model, covering all requirements
    cur_req = "R9";
    for (int i = 0; i < 2000; i++)
      step(2'($urandom), 2'($urandom), 2'($urandom), 2'($urandom),
           2'($urandom), 2'($urandom), 16'($urandom), 16'($urandom));

    // R7: reset in mid-run clears stored data
    cur_req = "R7";
    step('0, '0, '0, '0, '1, '1, 16'hBEEF, 16'hCAFE);
    @(negedge clk) rst = 1'b1;
    @(negedge clk) rst = 1'b0;
    step('0, 2'b10, '1, '1, '0, '0, 16'h1357, 16'h2468);
    step('0, 2'b01, '1, '1, '0, '0, 16'h9ABC, 16'hDEF0);

    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout, expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule